// File: doc/BRIEF.md
# Indexed Register Window with Keyed Core Reset

This block is the register front end of a serial bus controller. On the parallel host side it offers two direct registers: an index pointer and a data window. The window does not hold data itself. It passes each read or write through to whichever indirect register the pointer currently selects.

The indirect bank holds five configuration bytes: the controller's own bus address, a timeout count, an operating mode, and the low and high phase counts of the serial clock. Each byte drives an output port that the bus engine uses.

A reserved indirect index acts as a reset door. If the host selects that index and writes the byte 0xA5 and then the byte 0x5A through the window, the block emits a one-cycle reset pulse to the controller core. The same event returns the mode and the two clock-phase counts to their defaults. Software therefore reloads them after every such reset. Reading back the own-address byte after writing it is how software confirms that the indirect bank is present.

Top module: `ixreg_port`

## Requirements
- R1: After reset release, the pointer reads 0, the read data is 0x00, the core reset output is low, and the configuration outputs hold their defaults: own address 0xE0, timeout 0xFF, mode 0x00, clock low count 0x9D, clock high count 0x86.
- R2: A write to direct address 0 loads the pointer from the low 3 bits of the write data. A read of address 0 returns the pointer in bits 2:0, with the upper bits zero.
- R3: A write to direct address 1 (the window) updates the indirect register selected by the pointer: index 0 own address, 1 timeout, 2 mode, 3 clock low count, 4 clock high count. The new value appears on the matching output port, and a window read returns it.
- R4: The pointer keeps its value across window reads and writes and never auto-increments.
- R5: With the pointer at index 5, 6 or 7, a window read returns 0x00. A window write to index 5 or 7 changes no output.
- R6: With the pointer at index 6, a window write of 0xA5 followed by a window write of 0x5A drives the core reset output high for exactly one cycle. The pulse begins at the clock edge after the edge that accepts 0x5A.
- R7: The keyed reset returns mode, clock low count and clock high count to their defaults, in the same edge that raises the reset pulse. Own address and timeout keep their values.
- R8: After 0xA5 has been accepted at index 6, any other value written there (including another 0xA5) abandons the key. A later 0x5A then issues no reset, and the key must start again with 0xA5.
- R9: While the key is half entered, pointer writes and window writes to other indices do not disturb it.
- R10: A window write of 0x5A at index 6 without a pending 0xA5 issues no reset.
- R11: Direct addresses 2 and 3 read as 0x00, and writes to them change no output.
- R12: Read data is registered. It updates at the clock edge that samples the read strobe, and it holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 2 | Direct register address |
| wdata_i | input | 8 | Host write data |
| wr_en_i | input | 1 | Write strobe, one transfer per cycle high |
| rd_en_i | input | 1 | Read strobe, one transfer per cycle high |
| rdata_o | output | 8 | Registered read data |
| own_addr_o | output | 8 | Own bus address byte |
| timeout_o | output | 8 | Timeout count byte |
| mode_o | output | 8 | Operating mode byte |
| scl_lo_o | output | 8 | Serial clock low phase count |
| scl_hi_o | output | 8 | Serial clock high phase count |
| core_rst_o | output | 1 | One-cycle reset pulse to the controller core |

## Verification
The bench first writes and reads back every implemented index with distinct values. This separates a wrong index decode from a wrong port mapping. Repeated window accesses under a fixed pointer show that the pointer does not advance, and probes of indices 5, 6 and 7 and of addresses 2 and 3 show that unmapped locations read zero and ignore writes. The key is tried in several forms: 0x5A alone, 0xA5 followed by a wrong byte, a doubled 0xA5, an interleaved pointer and mode write, and the clean pair. Only the last two may pulse, and their pulses are checked cycle by cycle together with which registers were restored.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;

  // direct register addresses
  localparam int ADDR_PTR = 0;
  localparam int ADDR_WIN = 1;

  // indirect indices
  localparam int IX_OWN  = 0;
  localparam int IX_TO   = 1;
  localparam int IX_MODE = 2;
  localparam int IX_SLO  = 3;
  localparam int IX_SHI  = 4;
  localparam int IX_RST  = 6;
  localparam int IX_NREG = 5;

  // reset key bytes
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

endpackage

// File: rtl/ixreg_bank.sv
module ixreg_bank
  import ixreg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IXW  = 3,
  parameter int NREG = IX_NREG,
  parameter logic [NREG*DW-1:0] DEFS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [IXW-1:0]     idx_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               restore_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic [DW-1:0]      rd_val_o
);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [DW-1:0] DEF = DEFS[gi*DW +: DW];
    localparam bit RESTORABLE = (gi >= IX_MODE);
    logic [DW-1:0] r_q;
    logic [DW-1:0] r_d;
    logic          r_en;

    always_comb begin
      r_en = 1'b0;
      r_d  = r_q;
      if (RESTORABLE && restore_i) begin
        r_en = 1'b1;
        r_d  = DEF;
      end else if (we_i && (idx_i == IXW'(gi))) begin
        r_en = 1'b1;
        r_d  = wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= DEF;
      end else if (r_en) begin
        r_q <= r_d;
      end
    end

    assign regs_o[gi*DW +: DW] = r_q;
  end

  always_comb begin
    rd_val_o = '0;
    for (int k = 0; k < NREG; k++) begin
      if (idx_i == IXW'(k)) begin
        rd_val_o = regs_o[k*DW +: DW];
      end
    end
  end

  AST_MODE_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (regs_o[IX_MODE*DW +: DW] == DEFS[IX_MODE*DW +: DW])); // R7
  AST_SHI_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (regs_o[IX_SHI*DW +: DW] == DEFS[IX_SHI*DW +: DW])); // R7
  AST_OWN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !we_i) |=> $stable(regs_o[IX_OWN*DW +: DW])); // R7

endmodule

// File: rtl/ixreg_keyguard.sv
module ixreg_keyguard
  import ixreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kwe_i,
  input  logic [DW-1:0] wdata_i,
  output logic          restore_o,
  output logic          core_rst_o
);

  localparam logic [DW-1:0] K1 = DW'(KEY_FIRST);
  localparam logic [DW-1:0] K2 = DW'(KEY_SECOND);

  key_state_e state_q, state_d;
  logic       fire_q, fire_d;
  logic       pulse_q;

  always_comb begin
    state_d = state_q;
    fire_d  = 1'b0;
    case (state_q)
      KEY_IDLE: begin
        if (kwe_i && (wdata_i == K1)) begin
          state_d = KEY_ARMED;
        end
      end
      KEY_ARMED: begin
        if (kwe_i) begin
          state_d = KEY_IDLE;
          fire_d  = (wdata_i == K2);
        end
      end
      default: state_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
      fire_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
      pulse_q <= fire_q;
    end
  end

  assign restore_o  = fire_q;
  assign core_rst_o = pulse_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |=> !core_rst_o); // R6
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> core_rst_o); // R6
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> ($past(state_q) == KEY_ARMED)); // R10

endmodule

// File: rtl/ixreg_rdmux.sv
module ixreg_rdmux
  import ixreg_pkg::*;
#(
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int IXW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [IXW-1:0] ptr_i,
  input  logic [DW-1:0]  win_val_i,
  output logic [DW-1:0]  rdata_o
);

  logic [DW-1:0] sel;
  logic [DW-1:0] rdata_q;

  always_comb begin
    sel = '0;
    if (addr_i == AW'(ADDR_PTR)) begin
      sel = DW'(ptr_i);
    end else if (addr_i == AW'(ADDR_WIN)) begin
      sel = win_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= sel;
    end
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R12
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (addr_i != AW'(ADDR_PTR)) && (addr_i != AW'(ADDR_WIN)))
      |=> (rdata_o == '0)); // R11

endmodule

// File: rtl/ixreg_port.sv
module ixreg_port
  import ixreg_pkg::*;
#(
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int IXW = 3,
  parameter logic [DW-1:0] OWN_DEF  = 8'hE0,
  parameter logic [DW-1:0] TO_DEF   = 8'hFF,
  parameter logic [DW-1:0] MODE_DEF = 8'h00,
  parameter logic [DW-1:0] SLO_DEF  = 8'h9D,
  parameter logic [DW-1:0] SHI_DEF  = 8'h86
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] own_addr_o,
  output logic [DW-1:0] timeout_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] scl_lo_o,
  output logic [DW-1:0] scl_hi_o,
  output logic          core_rst_o
);

  localparam int NREG = IX_NREG;
  localparam logic [NREG*DW-1:0] DEFS = {SHI_DEF, SLO_DEF, MODE_DEF, TO_DEF, OWN_DEF};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign srst_n = rs_q[1];

  // pointer
  logic [IXW-1:0] ptr_q, ptr_d;
  logic           ptr_en;
  logic           win_we;
  logic           key_we;

  assign ptr_en = wr_en_i && (addr_i == AW'(ADDR_PTR));
  assign win_we = wr_en_i && (addr_i == AW'(ADDR_WIN));
  assign key_we = win_we && (ptr_q == IXW'(IX_RST));

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) begin
      ptr_d = wdata_i[IXW-1:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  logic [NREG*DW-1:0] regs;
  logic [DW-1:0]      win_val;
  logic               restore;

  ixreg_bank #(
    .DW   (DW),
    .IXW  (IXW),
    .NREG (NREG),
    .DEFS (DEFS)
  ) i_bank (
    .clk       (clk),
    .rst_n     (srst_n),
    .we_i      (win_we),
    .idx_i     (ptr_q),
    .wdata_i   (wdata_i),
    .restore_i (restore),
    .regs_o    (regs),
    .rd_val_o  (win_val)
  );

  ixreg_keyguard #(
    .DW (DW)
  ) i_key (
    .clk        (clk),
    .rst_n      (srst_n),
    .kwe_i      (key_we),
    .wdata_i    (wdata_i),
    .restore_o  (restore),
    .core_rst_o (core_rst_o)
  );

  ixreg_rdmux #(
    .AW  (AW),
    .DW  (DW),
    .IXW (IXW)
  ) i_rd (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .ptr_i     (ptr_q),
    .win_val_i (win_val),
    .rdata_o   (rdata_o)
  );

  assign own_addr_o = regs[IX_OWN*DW  +: DW];
  assign timeout_o  = regs[IX_TO*DW   +: DW];
  assign mode_o     = regs[IX_MODE*DW +: DW];
  assign scl_lo_o   = regs[IX_SLO*DW  +: DW];
  assign scl_hi_o   = regs[IX_SHI*DW  +: DW];

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !ptr_en |=> $stable(ptr_q)); // R4
  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!srst_n)
    core_rst_o |-> ((mode_o == MODE_DEF) && (scl_lo_o == SLO_DEF)
                    && (scl_hi_o == SHI_DEF))); // R7

endmodule

// File: tb/test_ixreg_port.sv
`timescale 1ns/1ps
module test_ixreg_port;

  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] rdata;
  logic [7:0] own_o, to_o, mode_o, slo_o, shi_o;
  logic       core_rst;

  ixreg_port i_ixreg_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .rdata_o    (rdata),
    .own_addr_o (own_o),
    .timeout_o  (to_o),
    .mode_o     (mode_o),
    .scl_lo_o   (slo_o),
    .scl_hi_o   (shi_o),
    .core_rst_o (core_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  bit done  = 1'b0;

  // model of configuration bytes
  logic [7:0] m_own = 8'hE0, m_to = 8'hFF, m_mode = 8'h00, m_slo = 8'h9D, m_shi = 8'h86;

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       chk_next = 1'b0;
  logic [7:0] mon_e;
  string      mon_t;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    chk_next <= rd_en;
    if (core_rst === 1'b1) pulses++;
  end

  always @(negedge clk) begin
    if (chk_next) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      chk(mon_t, rdata, mon_e);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ixw(input logic [2:0] ix, input logic [7:0] d);
    wr(2'd0, {5'd0, ix});
    wr(2'd1, d);
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " own"},  own_o,  m_own);
    chk({tag, " to"},   to_o,   m_to);
    chk({tag, " mode"}, mode_o, m_mode);
    chk({tag, " slo"},  slo_o,  m_slo);
    chk({tag, " shi"},  shi_o,  m_shi);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 core_rst", {7'd0, core_rst}, 8'h00);
    check_outs("R1");
    rd(2'd0, 8'h00, "R1 ptr");

    // R2 pointer
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h03, "R2 ptr=3");
    wr(2'd0, 8'hFD);
    rd(2'd0, 8'h05, "R2 ptr truncated");

    // R3 each indirect register
    ixw(3'd0, 8'h42); m_own  = 8'h42; rd(2'd1, 8'h42, "R3 own rb");
    ixw(3'd1, 8'h17); m_to   = 8'h17; rd(2'd1, 8'h17, "R3 to rb");
    ixw(3'd2, 8'h03); m_mode = 8'h03; rd(2'd1, 8'h03, "R3 mode rb");
    ixw(3'd3, 8'h21); m_slo  = 8'h21; rd(2'd1, 8'h21, "R3 slo rb");
    ixw(3'd4, 8'h12); m_shi  = 8'h12; rd(2'd1, 8'h12, "R3 shi rb");
    check_outs("R3");

    // R4 no auto-increment
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h11);
    wr(2'd1, 8'h22); m_to = 8'h22;
    rd(2'd1, 8'h22, "R4 window");
    rd(2'd1, 8'h22, "R4 window again");
    rd(2'd0, 8'h01, "R4 ptr kept");
    check_outs("R4");

    // R5 unimplemented indices
    ixw(3'd5, 8'h77);
    rd(2'd1, 8'h00, "R5 ix5 read");
    ixw(3'd7, 8'h66);
    rd(2'd1, 8'h00, "R5 ix7 read");
    check_outs("R5");
    wr(2'd0, 8'h06);
    rd(2'd1, 8'h00, "R5 ix6 read");

    // R11 unmapped direct addresses
    wr(2'd2, 8'h55);
    wr(2'd3, 8'hAA);
    rd(2'd2, 8'h00, "R11 addr2");
    rd(2'd3, 8'h00, "R11 addr3");
    check_outs("R11");
    rd(2'd0, 8'h06, "R11 ptr unchanged");

    // R12 rdata holds without read strobe
    rd(2'd0, 8'h06, "R12 prime");
    ixw(3'd6, 8'h00);
    wr(2'd2, 8'h13);
    chk("R12 hold", rdata, 8'h06);

    // R10 lone second key byte
    p0 = pulses;
    ixw(3'd6, 8'h5A);
    idle(3);
    chk("R10 no pulse", 8'(pulses - p0), 8'h00);
    check_outs("R10");

    // R8 broken keys
    p0 = pulses;
    wr(2'd1, 8'hA5); wr(2'd1, 8'h33); wr(2'd1, 8'h5A);
    idle(3);
    chk("R8 wrong byte", 8'(pulses - p0), 8'h00);
    wr(2'd1, 8'hA5); wr(2'd1, 8'hA5); wr(2'd1, 8'h5A);
    idle(3);
    chk("R8 double first", 8'(pulses - p0), 8'h00);
    check_outs("R8");

    // R6 clean key, exact pulse timing; R7 restore
    p0 = pulses;
    wr(2'd1, 8'hA5);
    wr(2'd1, 8'h5A);
    chk("R6 before edge", {7'd0, core_rst}, 8'h00);
    @(negedge clk);
    chk("R6 pulse high", {7'd0, core_rst}, 8'h01);
    m_mode = 8'h00; m_slo = 8'h9D; m_shi = 8'h86;
    check_outs("R7 restored");
    @(negedge clk);
    chk("R6 pulse low", {7'd0, core_rst}, 8'h00);
    idle(2);
    chk("R6 one pulse", 8'(pulses - p0), 8'h01);
    rd(2'd0, 8'h06, "R7 ptr kept");

    // R9 interleaved accesses keep key armed
    ixw(3'd3, 8'h44); m_slo = 8'h44;
    p0 = pulses;
    ixw(3'd6, 8'hA5);
    ixw(3'd2, 8'h09); m_mode = 8'h09;
    wr(2'd0, 8'h06);
    wr(2'd1, 8'h5A);
    @(negedge clk);
    chk("R9 pulse", {7'd0, core_rst}, 8'h01);
    m_mode = 8'h00; m_slo = 8'h9D;
    check_outs("R9 R7");
    idle(2);
    chk("R9 one pulse", 8'(pulses - p0), 8'h01);

    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule